// File: doc/BRIEF.md
# Crystal-Driven Square-Wave Tone Divider

This block derives an audible square wave from a 32768 Hz crystal. The crystal is not used as a clock. It arrives as a one-cycle enable pulse, `xtal_tick`, inside a faster system clock domain. A host writes an 8-bit divisor into the block. A down-counter counts crystal ticks from that divisor to zero. On each underflow it reloads and flips the tone. A divisor `p` therefore gives a tone of 32768 / (2 × (p + 1)) Hz, and each divisor value selects one musical pitch.

A small 3-bit control register sits beside the divisor. One bit switches the crystal source off. Two bits choose a loudness level. The loudness is applied by gating the tone with a fast pulse-width pattern taken from a free-running phase counter. That gated output is meant to drive a speaker through a simple filter. The block never picks notes itself: every divisor comes from the host.

Top module: `tone_gen`

## Requirements
- R1: An asynchronous reset, and a one-cycle `sync_clr` pulse, drive both tone outputs low and clear the divisor and the control register to zero. After this the volume is 00 and the crystal is enabled.
- R2: While running, the tone flips after exactly divisor + 1 crystal ticks, so one full period is 2 × (divisor + 1) ticks. This holds for divisors 00h and FFh.
- R3: Divisors 3Eh, 7Ch, 10h and 20h give 260.06 Hz, 131.07 Hz, 963.76 Hz and 496.48 Hz, each within 0.01 Hz, from a 32768 Hz tick rate.
- R4: A divisor written in the middle of a half period does not shorten or stretch that half period. The new value is used from the next reload onward.
- R5: While `run_en` is low, or the crystal-off bit is 1, `tone_o` and `tone_vol_o` stay low.
- R6: A write to the control register stores `mode_data`. Bit 2 is crystal-off (1 = off). Bits 1:0 are the volume code.
- R7: Volume code 00 holds `tone_vol_o` low while `tone_o` keeps toggling.
- R8: While `tone_o` is high, `tone_vol_o` is high on 1 of every 4 system clocks for code 01 and on 2 of every 4 for code 10. For code 11, `tone_vol_o` equals `tone_o`.
- R9: `tone_o` rises only in the clock cycle that follows a `xtal_tick` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_clr | input | 1 | Synchronous clear of all state |
| xtal_tick | input | 1 | One-cycle pulse at the 32768 Hz crystal rate |
| preset_we | input | 1 | Divisor write strobe |
| preset_data | input | 8 | Divisor value |
| mode_we | input | 1 | Control register write strobe |
| mode_data | input | 3 | Bit 2 crystal-off, bits 1:0 volume code |
| run_en | input | 1 | Tone generation enable |
| tone_o | output | 1 | Square-wave tone |
| tone_vol_o | output | 1 | Tone gated by the volume duty pattern |

## Verification
Period measurements cover the four named pitches, the extreme divisors 00h and FFh, and a seeded set of random divisors. Together they separate an off-by-one reload from a correct one and reveal a counter that is too narrow.

A divisor change made just after a rising edge tells reload-time loading apart from immediate loading: the high half keeps the old length while the low half takes the new one. Counting the high cycles of the gated output inside one tone-high window tells the four volume codes apart. Idling through `run_en`, the crystal-off bit and `sync_clr` shows that each of them forces the output low.

// File: rtl/tone_pkg.sv
package tone_pkg;
  typedef enum logic [1:0] {
    VOL_MUTE = 2'b00,
    VOL_QTR  = 2'b01,
    VOL_HALF = 2'b10,
    VOL_FULL = 2'b11
  } vol_e;

  typedef struct packed {
    logic xtal_off;
    vol_e vol;
  } mode_t;
endpackage

// File: rtl/tone_divider.sv
module tone_divider #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic             run,
  input  logic [CNT_W-1:0] preset,
  output logic             tone
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tone_q, tone_d;

  always_comb begin
    cnt_d  = cnt_q;
    tone_d = tone_q;
    if (clr || !run) begin
      cnt_d  = preset;
      tone_d = 1'b0;
    end else if (tick) begin
      if (cnt_q == '0) begin
        cnt_d  = preset;
        tone_d = ~tone_q;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tone_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tone_q <= tone_d;
    end
  end

  assign tone = tone_q;

  // R5
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tone_q);

  // R9
  tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && !tick) |=> $stable(tone_q));

  // R2
  hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && tick && cnt_q != '0) |=> $stable(tone_q));
endmodule

// File: rtl/tone_pwm.sv
module tone_pwm
  import tone_pkg::*;
#(
  parameter int PH_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  vol_e vol,
  input  logic tone_in,
  output logic tone_out
);
  localparam int PH_N = 1 << PH_W;
  localparam logic [PH_W:0] QTR_L  = (PH_W+1)'(PH_N / 4);
  localparam logic [PH_W:0] HALF_L = (PH_W+1)'(PH_N / 2);

  logic [PH_W-1:0] ph_q, ph_d;
  logic            gate;

  always_comb begin
    ph_d = clr ? '0 : ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  always_comb begin
    unique case (vol)
      VOL_MUTE: gate = 1'b0;
      VOL_QTR:  gate = ({1'b0, ph_q} < QTR_L);
      VOL_HALF: gate = ({1'b0, ph_q} < HALF_L);
      default:  gate = 1'b1;
    endcase
  end

  assign tone_out = tone_in & gate;

  // R7
  mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vol == VOL_MUTE) |-> !tone_out);

  // R8
  full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vol == VOL_FULL) |-> (tone_out == tone_in));

  // R8
  gate_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tone_out |-> tone_in);
endmodule

// File: rtl/tone_gen.sv
module tone_gen
  import tone_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PH_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_clr,
  input  logic             xtal_tick,
  input  logic             preset_we,
  input  logic [CNT_W-1:0] preset_data,
  input  logic             mode_we,
  input  logic [2:0]       mode_data,
  input  logic             run_en,
  output logic             tone_o,
  output logic             tone_vol_o
);
  logic             rs0_q, rs1_q, rst_int_n;
  logic [CNT_W-1:0] preset_q, preset_d;
  mode_t            mode_q, mode_d;
  logic             running;
  logic             tone_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs0_q <= 1'b0;
      rs1_q <= 1'b0;
    end else begin
      rs0_q <= 1'b1;
      rs1_q <= rs0_q;
    end
  end
  assign rst_int_n = rs1_q;

  always_comb begin
    preset_d = preset_q;
    mode_d   = mode_q;
    if (sync_clr) begin
      preset_d = '0;
      mode_d   = '0;
    end else begin
      if (preset_we) preset_d = preset_data;
      if (mode_we)   mode_d   = mode_t'(mode_data);
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      preset_q <= '0;
      mode_q   <= '0;
    end else begin
      preset_q <= preset_d;
      mode_q   <= mode_d;
    end
  end

  assign running = run_en && !mode_q.xtal_off;

  tone_divider #(.CNT_W(CNT_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr    (sync_clr),
    .tick   (xtal_tick),
    .run    (running),
    .preset (preset_q),
    .tone   (tone_raw)
  );

  tone_pwm #(.PH_W(PH_W)) u_pwm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clr      (sync_clr),
    .vol      (mode_q.vol),
    .tone_in  (tone_raw),
    .tone_out (tone_vol_o)
  );

  assign tone_o = tone_raw;

  // R1
  clr_state_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    sync_clr |=> (mode_q == '0 && preset_q == '0 && !tone_o));

  // R6
  mode_wr_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode_we && !sync_clr) |=> (mode_q == $past(mode_data)));

  // R5
  xtal_off_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    mode_q.xtal_off |=> !tone_o);
endmodule

// File: tb/tone_gen_bench.sv
module tone_gen_bench;
  localparam int TICK_DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n, sync_clr, xtal_tick, preset_we, mode_we, run_en;
  logic [7:0] preset_data;
  logic [2:0] mode_data;
  logic       tone_o, tone_vol_o;

  int total = 0;
  int bad = 0;
  int r9_bad = 0;
  bit done = 0;
  bit tick_on = 0;
  int tcnt = 0;
  logic tone_prev = 1'b0;

  always #5 clk = ~clk;

  tone_gen u_tone_gen (
    .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .xtal_tick(xtal_tick),
    .preset_we(preset_we), .preset_data(preset_data), .mode_we(mode_we),
    .mode_data(mode_data), .run_en(run_en), .tone_o(tone_o),
    .tone_vol_o(tone_vol_o)
  );

  // Tick generator and R9 monitor: a rise must follow a driven tick.
  always @(negedge clk) begin
    if (tick_on && rst_n && !tone_prev && tone_o && !xtal_tick) r9_bad++;
    tone_prev = tone_o;
    if (!tick_on) begin
      tcnt = 0;
      xtal_tick = 1'b0;
    end else begin
      tcnt = (tcnt == TICK_DIV-1) ? 0 : tcnt + 1;
      xtal_tick = (tcnt == 0);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_period(input int p);
    return 2 * (p + 1) * TICK_DIV;
  endfunction

  task automatic write_preset(input int p);
    preset_data = 8'(p);
    preset_we = 1'b1;
    @(negedge clk);
    preset_we = 1'b0;
  endtask

  task automatic write_mode(input logic [2:0] m);
    mode_data = m;
    mode_we = 1'b1;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  task automatic wait_rise(output bit ok);
    logic p;
    ok = 0;
    p = tone_o;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (!p && tone_o) begin
        ok = 1;
        break;
      end
      p = tone_o;
    end
  endtask

  task automatic meas_period(output int clks, output int vol_hi);
    bit ok;
    logic p;
    clks = 0;
    vol_hi = 0;
    wait_rise(ok);
    wait_rise(ok);
    p = tone_o;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      clks++;
      if (tone_vol_o) vol_hi++;
      if (!p && tone_o) break;
      p = tone_o;
    end
  endtask

  task automatic period_case(input int p, input string req);
    int c, v;
    write_preset(p);
    meas_period(c, v);
    check(c == exp_period(p), req, $sformatf("period preset %0h", p), c, exp_period(p));
  endtask

  task automatic freq_case(input int p, input real hz);
    int c, v;
    real f;
    write_preset(p);
    meas_period(c, v);
    f = 32768.0 * TICK_DIV / real'(c);
    check((f - hz) < 0.01 && (hz - f) < 0.01, "R3",
          $sformatf("freq x100 preset %0h", p), int'(f * 100.0), int'(hz * 100.0));
  endtask

  task automatic count_low(input int n, output int tone_hi, output int vol_hi);
    tone_hi = 0;
    vol_hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tone_o) tone_hi++;
      if (tone_vol_o) vol_hi++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c, v, th, vh, p;
    bit ok;
    void'($urandom(32'h5eed1234));
    rst_n = 1'b0; sync_clr = 1'b0; preset_we = 1'b0; mode_we = 1'b0;
    run_en = 1'b0; preset_data = '0; mode_data = '0;
    repeat (4) @(negedge clk);
    check(tone_o == 1'b0 && tone_vol_o == 1'b0, "R1", "outputs in reset", tone_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    tick_on = 1;
    check(tone_o == 1'b0, "R1", "tone after reset", tone_o, 0);

    // Default control register: crystal on, muted volume.
    run_en = 1'b1;
    write_preset(8'h3E);
    meas_period(c, v);
    check(c == exp_period(8'h3E), "R1", "crystal enabled by default", c, exp_period(8'h3E));
    check(v == 0, "R7", "muted by default", v, 0);

    freq_case(8'h3E, 260.06);
    freq_case(8'h7C, 131.07);
    freq_case(8'h10, 963.76);
    freq_case(8'h20, 496.48);
    period_case(8'h00, "R2");
    period_case(8'hFF, "R2");
    for (int k = 0; k < 6; k++) begin
      p = int'($urandom_range(0, 95));
      period_case(p, "R2");
    end

    // Volume codes.
    write_preset(8'h20);
    write_mode(3'b011);
    c = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (tone_vol_o != tone_o) c++;
    end
    check(c == 0, "R8", "full volume mismatches", c, 0);

    write_mode(3'b001);
    wait_rise(ok);
    count_low(40, th, vh);
    check(vh == 10, "R8", "quarter duty highs in 40", vh, 10);

    write_mode(3'b010);
    wait_rise(ok);
    count_low(40, th, vh);
    check(vh == 20, "R8", "half duty highs in 40", vh, 20);

    write_mode(3'b000);
    write_preset(8'h00);
    count_low(200, th, vh);
    check(vh == 0 && th > 0, "R7", "mute highs with tone moving", vh, 0);

    // Mid-period divisor change: the high half keeps the old length.
    write_preset(8'h20);
    wait_rise(ok);
    wait_rise(ok);
    preset_data = 8'h05;
    preset_we = 1'b1;
    c = 0;
    do begin
      @(negedge clk);
      preset_we = 1'b0;
      c++;
    end while (tone_o && c < 2000);
    check(c == 33 * TICK_DIV, "R4", "high half after write", c, 33 * TICK_DIV);
    v = 0;
    do begin
      @(negedge clk);
      v++;
    end while (!tone_o && v < 2000);
    check(v == 6 * TICK_DIV, "R4", "low half with new divisor", v, 6 * TICK_DIV);

    // Idle by run_en, then by the crystal-off bit.
    write_mode(3'b011);
    run_en = 1'b0;
    @(negedge clk);
    count_low(200, th, vh);
    check(th == 0 && vh == 0, "R5", "run low tone highs", th + vh, 0);
    run_en = 1'b1;
    write_mode(3'b111);
    @(negedge clk);
    count_low(200, th, vh);
    check(th == 0 && vh == 0, "R6", "crystal-off tone highs", th + vh, 0);
    write_mode(3'b011);
    meas_period(c, v);
    check(c == exp_period(5), "R6", "crystal back on period", c, exp_period(5));

    // Synchronous clear.
    write_preset(8'h30);
    wait_rise(ok);
    sync_clr = 1'b1;
    @(negedge clk);
    sync_clr = 1'b0;
    check(tone_o == 1'b0, "R1", "tone after sync_clr", tone_o, 0);
    meas_period(c, v);
    check(c == exp_period(0), "R1", "divisor cleared period", c, exp_period(0));
    check(v == 0, "R1", "volume cleared to mute", v, 0);

    check(r9_bad == 0, "R9", "rises without a tick", r9_bad, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule